// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block moves a single logic-one through a chain of N registers, one position per clock edge, and presents the whole one-hot vector as its output. It suits sequencers, phase selectors and round-robin strobes, where each output bit enables one step and exactly one step may be active at a time.

The block has no asynchronous set or clear. Every register bit sits behind a two-way data multiplexer. One leg carries the shifted value from its neighbour. The other leg carries the fixed start pattern, which is bit 0 high and all other bits low. That start pattern is selected on three conditions. The first is a low level on the active-low initialisation input, which is the only reset and acts synchronously. The second is the top bit being set, so the ring returns to position zero. The third is a register that holds no ones at all. Because the reload also happens at every lap boundary, extra ones or an empty ring caused by power-up or upset are flushed within one lap, without any reset. The wrap output marks the cycle in which the one sits in the top position.

The register contents before the first edge are set by a parameter. This models an arbitrary power-up or upset state, so self-correction can be shown at the ports. Control pins are plain levels, and there is no streaming interface.

Top module: `ring_counter`

## Requirements
- R1: A clock edge at which `init_n` is low loads the start pattern: `ring_q` becomes 1 in bit 0 and 0 in all other bits, whatever it held before.
- R2: With `init_n` high and `ring_q` holding a single one below bit N-1, each clock edge moves that one up by one position (bit i takes the old bit i-1).
- R3: With `init_n` high and bit N-1 of `ring_q` set, the next clock edge loads the start pattern and discards any other ones present.
- R4: With `init_n` high and `ring_q` all zero, the next clock edge loads the start pattern.
- R5: `wrap` is high in exactly those cycles in which bit N-1 of `ring_q` is high, so for a legal ring it is a one-cycle pulse once every N cycles.
- R6: From any power-up content, including several ones or none, `ring_q` holds exactly one set bit no later than N+1 clock edges after start, with `init_n` held high throughout.
- R7: Before the first clock edge, `ring_q` holds the value of the parameter `POWERUP_PAT`. No asynchronous input changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| init_n | input | 1 | Active-low synchronous initialisation; low loads the start pattern |
| ring_q | output | N | One-hot ring state, bit 0 is position zero |
| wrap | output | 1 | High while the one is in position N-1 |

## Verification
The properties in the RTL check every cycle that initialisation, the top-bit reload and the empty-ring reload all give the start pattern on the next edge. They also check that a legal one moves up exactly one place, and that no run of illegal states grows longer than N cycles. Only the bench scenarios can show convergence from specific power-up patterns, such as a sparse multi-one ring and an empty ring, at defined clock counts. The bench also checks the wrap pulse against a reference model under random initialisation pulses.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // why the next edge takes the start pattern instead of shifting
  typedef enum logic [1:0] {
    RLD_NONE  = 2'd0,
    RLD_INIT  = 2'd1,
    RLD_WRAP  = 2'd2,
    RLD_EMPTY = 2'd3
  } reload_cause_e;
endpackage

// File: rtl/ring_reload_detect.sv
module ring_reload_detect
  import ring_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]  state,
  input  logic          init_n,
  output logic          reload,
  output reload_cause_e cause
);
  logic empty;
  assign empty = (state == '0);

  // initialisation takes priority, then lap wrap, then empty ring
  always_comb begin
    if (!init_n)           cause = RLD_INIT;
    else if (state[N-1])   cause = RLD_WRAP;
    else if (empty)        cause = RLD_EMPTY;
    else                   cause = RLD_NONE;
  end

  assign reload = (cause != RLD_NONE);
endmodule

// File: rtl/ring_cell.sv
module ring_cell #(
  parameter bit POWERUP  = 1'b0,
  parameter bit LOAD_VAL = 1'b0
) (
  input  logic clk,
  input  logic load,
  input  logic shift_in,
  output logic q
);
  logic bit_q = POWERUP;

  // data mux in front of the flop: start pattern or neighbour
  always_ff @(posedge clk) begin
    if (load) bit_q <= LOAD_VAL;
    else      bit_q <= shift_in;
  end

  assign q = bit_q;
endmodule

// File: rtl/ring_counter.sv
module ring_counter
  import ring_pkg::*;
#(
  parameter int           N           = 8,
  parameter logic [N-1:0] POWERUP_PAT = '0
) (
  input  logic         clk,
  input  logic         init_n,
  output logic [N-1:0] ring_q,
  output logic         wrap
);
  localparam logic [N-1:0] START = {{(N-1){1'b0}}, 1'b1};
  localparam int           RUN_W = $clog2(N + 2) + 1;

  logic [N-1:0]  state;
  logic          reload;
  reload_cause_e cause;

  initial begin
    if (N < 2) $error("ring_counter: N must be at least 2");
  end

  ring_reload_detect #(.N(N)) u_detect (
    .state  (state),
    .init_n (init_n),
    .reload (reload),
    .cause  (cause)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int SRC = (i == 0) ? N - 1 : i - 1;
    ring_cell #(
      .POWERUP  (POWERUP_PAT[i]),
      .LOAD_VAL (START[i])
    ) u_cell (
      .clk      (clk),
      .load     (reload),
      .shift_in (state[SRC]),
      .q        (state[i])
    );
  end

  assign ring_q = state;
  assign wrap   = state[N-1];

  // ---------------------------------------------------------------
  // checks
  // ---------------------------------------------------------------
  logic [RUN_W-1:0] bad_run = '0;
  always_ff @(posedge clk) begin
    if (!init_n || ($countones(state) == 1)) bad_run <= '0;
    else if (bad_run != '1)                  bad_run <= bad_run + 1'b1;
  end

  // R1
  init_load_chk: assert property (@(posedge clk)
    !init_n |=> (ring_q == START));

  // R2
  shift_up_chk: assert property (@(posedge clk) disable iff (!init_n)
    (($countones(ring_q) == 1) && !ring_q[N-1]) |=> (ring_q == ($past(ring_q) << 1)));

  // R3
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!init_n)
    ring_q[N-1] |=> (ring_q == START));

  // R4
  empty_reload_chk: assert property (@(posedge clk) disable iff (!init_n)
    (ring_q == '0) |=> (ring_q == START));

  // R6
  converge_chk: assert property (@(posedge clk) disable iff (!init_n)
    (bad_run <= RUN_W'(N)));
endmodule

// File: tb/ring_counter_test.sv
module ring_counter_test;
  localparam int           N     = 8;
  localparam logic [N-1:0] START = 8'b0000_0001;
  localparam logic [N-1:0] MULTI = 8'b0010_0110;

  logic         clk = 1'b0;
  logic         init_n = 1'b0;
  logic [N-1:0] q_main, q_zero, q_multi;
  logic         w_main, w_zero, w_multi;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ring_counter #(.N(N)) uut (
    .clk(clk), .init_n(init_n), .ring_q(q_main), .wrap(w_main));
  ring_counter #(.N(N), .POWERUP_PAT('0)) uut_zero (
    .clk(clk), .init_n(1'b1), .ring_q(q_zero), .wrap(w_zero));
  ring_counter #(.N(N), .POWERUP_PAT(MULTI)) uut_multi (
    .clk(clk), .init_n(1'b1), .ring_q(q_multi), .wrap(w_multi));

  // expected next state from the requirements (R1..R4)
  function automatic logic [N-1:0] model_next(input logic [N-1:0] s, input logic i_n);
    if (!i_n)        return START;
    if (s[N-1])      return START;
    if (s == '0)     return START;
    return s << 1;
  endfunction

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [N-1:0] exp_m, exp_z, exp_x;
    int wraps;
    void'($urandom(32'd4242));

    // R7: power-up contents visible before any edge
    #1;
    check_vec("R7 zero power-up", q_zero, '0);
    check_vec("R7 multi power-up", q_multi, MULTI);

    exp_m = START;
    exp_z = model_next('0, 1'b1);
    exp_x = model_next(MULTI, 1'b1);

    // cycle 1: first edge had init_n low (R1 reset state)
    @(negedge clk);
    check_vec("R1 reset state", q_main, START);
    check_bit("R5 no wrap at reset", w_main, 1'b0);
    check_vec("R4 empty ring reload", q_zero, START);

    // let init go high, run one clean lap (R2, R5, R3)
    init_n = 1'b1;
    exp_m  = model_next(exp_m, init_n);
    exp_z  = model_next(exp_z, 1'b1);
    exp_x  = model_next(exp_x, 1'b1);
    wraps  = 0;
    for (int c = 2; c <= 2 * N + 2; c++) begin
      @(negedge clk);
      check_vec("R2 lap shift", q_main, exp_m);
      check_bit("R5 wrap pulse", w_main, exp_m[N-1]);
      check_vec("R4 zero instance", q_zero, exp_z);
      check_vec("R3 multi instance", q_multi, exp_x);
      check_bit("R5 multi wrap", w_multi, exp_x[N-1]);
      if (w_main) wraps++;
      if (c == N + 1) begin
        check_bit("R6 zero converged", $countones(q_zero) == 1, 1'b1);
        check_bit("R6 multi converged", $countones(q_multi) == 1, 1'b1);
      end
      exp_m = model_next(exp_m, init_n);
      exp_z = model_next(exp_z, 1'b1);
      exp_x = model_next(exp_x, 1'b1);
    end
    check_bit("R5 wrap count over two laps", wraps == 2, 1'b1);

    // directed: init mid-lap restarts from bit 0 (R1)
    @(negedge clk);
    init_n = 1'b0;
    exp_m  = model_next(q_main, init_n);
    @(negedge clk);
    check_vec("R1 init mid-lap", q_main, START);
    init_n = 1'b1;
    exp_m  = model_next(exp_m, init_n);

    // constrained random init pulses, checked every cycle
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      check_vec("R2 random run", q_main, exp_m);
      check_bit("R5 random wrap", w_main, exp_m[N-1]);
      init_n = (($urandom % 8) != 0);
      exp_m  = model_next(exp_m, init_n);
    end

    finish_run();
  end
endmodule